// File: doc/BRIEF.md
# Byte-Lane Bus Parity Unit

This block handles per-byte even parity for a 64-bit data bus that is split into eight byte lanes. In the write direction it derives one parity bit per lane from the outgoing data. This path is purely combinational, so the parity bits can travel with the data in the same cycle.

In the read direction, a read strobe samples the incoming data together with its parity bits. The block checks only the lanes that the active-low byte enables select. An active-low enable input decides whether a failure is reported. The result appears on an active-low check output that is registered and valid in the cycle after the strobe.

Top module: `lane_parity_unit`

## Requirements
- R1: Output `wr_par[k]` is the XOR of `wr_data[8k+7:8k]`, so each lane's data plus its parity bit holds an even number of ones. It follows `wr_data` combinationally for all eight lanes and does not depend on `be_n`.
- R2: On a read, lane k fails when `rd_data[8k+7:8k]` together with `rd_par[k]` holds an odd number of ones. Bit 0 of the parity belongs to the least significant byte and bit 7 to the most significant byte.
- R3: Only lanes with `be_n[k]` = 0 are checked, with `be_n[0]` selecting the least significant byte. A failing lane whose enable bit is 1 never causes an error.
- R4: While `par_en_n` = 1 in the strobe cycle, `chk_n` stays 1 regardless of data, parity and enables.
- R5: When `rd_strobe` = 1, `par_en_n` = 0 and at least one enabled lane fails at a clock edge, `chk_n` is 0 for the following cycle only. It returns to 1 unless that next edge also samples a failing read.
- R6: Without `rd_strobe`, `chk_n` is 1 in the following cycle, whatever the read inputs are.
- R7: While `rst_n` is 0, `chk_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data | input | 64 | Outgoing write data |
| wr_par | output | 8 | Even parity per lane of wr_data |
| rd_data | input | 64 | Incoming read data |
| rd_par | input | 8 | Incoming parity per lane |
| be_n | input | 8 | Active-low byte enables, bit 0 = lane 0 |
| par_en_n | input | 1 | Active-low parity report enable |
| rd_strobe | input | 1 | Samples read data for checking |
| chk_n | output | 1 | Active-low registered parity error |

## Verification
The bench flips single bits in the lowest and highest lanes, with the matching enable bit set and then cleared. A design with reversed lane order, or with an active-high reading of the enables, would flag the wrong lanes. It also tries two flips in one lane, which leaves the parity even, and checks that no error appears. A design that detected any change rather than parity would report there. Back-to-back failing strobes followed by an idle cycle, a disabled report, and all lanes disabled are all driven. A sticky error, a missing gate, or a result taken in the wrong cycle would show up as a mismatch against the cycle-by-cycle model.

// File: rtl/lane_parity_unit.sv
module lane_parity_unit #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES*LANE_W-1:0] wr_data,
  output logic [LANES-1:0]        wr_par,
  input  logic [LANES*LANE_W-1:0] rd_data,
  input  logic [LANES-1:0]        rd_par,
  input  logic [LANES-1:0]        be_n,
  input  logic                    par_en_n,
  input  logic                    rd_strobe,
  output logic                    chk_n
);

  logic [LANES-1:0] lane_bad;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign wr_par[k]   = ^wr_data[k*LANE_W +: LANE_W];
    assign lane_bad[k] = (^{rd_data[k*LANE_W +: LANE_W], rd_par[k]}) & ~be_n[k];
  end

  wire fail = rd_strobe & ~par_en_n & (|lane_bad);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) chk_n <= 1'b1;
    else        chk_n <= ~fail;

  AST_LOW_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_n |-> ($past(rd_strobe) && !$past(par_en_n))); // R5
  AST_REPORT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    par_en_n |=> chk_n); // R4
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> chk_n); // R6
  AST_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (&be_n) |=> chk_n); // R3

endmodule

// File: tb/lane_parity_unit_bench.sv
module lane_parity_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] wr_data = '0;
  logic [7:0]  wr_par;
  logic [63:0] rd_data = '0;
  logic [7:0]  rd_par = '0;
  logic [7:0]  be_n = '1;
  logic        par_en_n = 1;
  logic        rd_strobe = 0;
  logic        chk_n;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_parity_unit u_lane_parity_unit (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_par(wr_par),
    .rd_data(rd_data), .rd_par(rd_par), .be_n(be_n),
    .par_en_n(par_en_n), .rd_strobe(rd_strobe), .chk_n(chk_n));

  function automatic int ones(input logic [7:0] b);
    int n = 0;
    for (int i = 0; i < 8; i++) if (b[i]) n++;
    return n;
  endfunction

  function automatic logic [7:0] good_par(input logic [63:0] d);
    logic [7:0] p;
    for (int k = 0; k < 8; k++) p[k] = (ones(d[8*k +: 8]) % 2) == 1;
    return p;
  endfunction

  function automatic logic model_chk(input logic [63:0] d, input logic [7:0] p,
                                     input logic [7:0] be, input logic en_n,
                                     input logic st);
    int failing = 0;
    for (int k = 0; k < 8; k++)
      if (!be[k] && ((ones(d[8*k +: 8]) + int'(p[k])) % 2 == 1)) failing++;
    return !(st && !en_n && failing > 0);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [63:0] d, input logic [7:0] p, input logic [7:0] be,
                      input logic en_n, input logic st, input string tag);
    logic e;
    rd_data = d; rd_par = p; be_n = be; par_en_n = en_n; rd_strobe = st;
    wr_data = {d[31:0], d[63:32]} ^ 64'h0123_4567_89ab_cdef;
    #1;
    check("R1 wr_par", wr_par, good_par(wr_data));
    e = model_chk(d, p, be, en_n, st);
    @(posedge clk);
    @(negedge clk);
    check(tag, {7'b0, chk_n}, {7'b0, e});
  endtask

  initial begin
    #(CLK_PERIOD*50000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] d;
    rd_data = 64'h1; rd_par = 8'h0; be_n = 8'h0; par_en_n = 0; rd_strobe = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 reset", {7'b0, chk_n}, 8'h01);
    rd_strobe = 0;
    @(negedge clk);
    rst_n = 1;
    d = 64'hdead_beef_cafe_f00d;
    step(d, good_par(d), 8'h00, 0, 1, "R2 clean read");
    step(d ^ 64'h1, good_par(d), 8'h00, 0, 1, "R2 lane0 flip");
    step(d ^ 64'h1, good_par(d), 8'h01, 0, 1, "R3 lane0 disabled");
    step(d ^ 64'h1, good_par(d), 8'hfe, 0, 1, "R3 lane0 only enabled");
    step(d ^ (64'h1 << 63), good_par(d), 8'h7f, 0, 1, "R3 lane7 enabled");
    step(d ^ (64'h1 << 63), good_par(d), 8'h80, 0, 1, "R3 lane7 disabled");
    step(d ^ 64'h3, good_par(d), 8'h00, 0, 1, "R2 double flip even");
    step(d, ~good_par(d), 8'hff, 0, 1, "R3 no lanes");
    step(d, ~good_par(d), 8'h00, 1, 1, "R4 report off");
    step(d, ~good_par(d), 8'h00, 0, 0, "R6 no strobe");
    step(d, ~good_par(d), 8'h00, 0, 1, "R5 first fail");
    step(d, ~good_par(d), 8'h00, 0, 1, "R5 second fail");
    step(d, ~good_par(d), 8'h00, 0, 0, "R5 release");
    for (int i = 0; i < 400; i++) begin
      logic [63:0] rd;
      logic [7:0]  rp;
      rd = {$urandom, $urandom};
      rp = good_par(rd) ^ ((($urandom % 3) == 0) ? 8'(1 << ($urandom % 8)) : 8'h0);
      step(rd, rp, 8'($urandom), ($urandom % 5) == 0, ($urandom % 4) != 0, "R5 random");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule